// File: doc/BRIEF.md
# Indirect Register Mailbox Port

This block gives a host a narrow, byte-wide path into an internal register file through two host locations. One location carries data bytes. The other is read as a status byte and written as a command byte. The host does not address the register file directly. It first writes a command byte that selects a register read or a register write. It then writes the register index to the data location. For a write it follows with the value. For a read it waits for a result byte to appear in the data location.

Two handshake flags pace the host. The input-busy flag is raised for a fixed number of cycles after each byte written to the data or command location, while the byte is being consumed. The output-ready flag is raised when a read result is waiting. A third location holds an interrupt-control byte, which is passed straight to an output for the engine that sits behind the register file. That engine also sees the register file through its own read port.

Top module: `mbx_port`

## Requirements
- R1: After synchronous reset, host_rdata and intr_ctrl are 0x00. The status byte reads 0x00, and the data location reads 0x00.
- R2: The host map is as follows. The data location is at 0x0 and the status/command location is at 0x4. The interrupt-control location is at 0x8. In the status byte, bit 0 is output-ready, bit 1 is input-busy and bit 3 is the command flag. All other status bits read 0. Reads of unmapped addresses return 0x00. Read data appears on host_rdata one cycle after host_rd.
- R3: A write to 0x0 or 0x4 that is accepted while input-busy is clear raises input-busy for exactly BUSY_CYC cycles. The byte is acted on in the last of those cycles.
- R4: A write to 0x0 or 0x4 while input-busy is set is dropped and has no effect.
- R5: An accepted command byte sets the command flag. An accepted data byte clears it.
- R6: Command 0x80 followed by an index byte starts a register read. The low IDX_W bits of the index select the register. The register value is then placed in the data location and output-ready rises one cycle after input-busy falls.
- R7: Command 0x81, then an index byte, then a value byte writes the value into the selected register.
- R8: A host read of the data location clears output-ready. If a new result is loaded in the same cycle, output-ready stays set. The read returns the old byte, and the new byte is returned by the next read.
- R9: A command byte always restarts the sequence and drops any index already received. A command byte other than 0x80 or 0x81 returns the sequencer to idle.
- R10: A data byte that arrives with no command pending is ignored. It does not raise output-ready and it does not change any register.
- R11: eng_rdata shows the register selected by eng_idx, one cycle after eng_idx is presented.
- R12: A write to 0x8 stores the byte immediately, without input-busy. The byte reads back at 0x8 and drives intr_ctrl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| eng_idx | input | IDX_W | Engine-side register index |
| eng_rdata | output | 8 | Engine-side register value |
| intr_ctrl | output | 8 | Interrupt-control byte |

## Verification
The two functions that can fall in the same cycle are the load of a fresh read result into the data location and a host read of that location, which would clear output-ready. The bench provokes this collision on purpose. It leaves an earlier result unread, starts a second register read, and times a data read to land exactly one cycle after the index byte's busy window ends. It then judges the outcome from three observations: the collided read must return the old byte, the status must still show output-ready, and the following read must return the new register value.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW = 8;

  // host byte offsets
  localparam int OFS_DATA = 'h0;
  localparam int OFS_CSR  = 'h4;
  localparam int OFS_INTC = 'h8;

  // status bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;

  // command codes
  localparam logic [DW-1:0] CMD_RD = 8'h80;
  localparam logic [DW-1:0] CMD_WR = 8'h81;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RD_IDX = 2'd1,
    SQ_WR_IDX = 2'd2,
    SQ_WR_VAL = 2'd3
  } sq_state_t;
endpackage

// File: rtl/mbx_busy.sv
module mbx_busy #(
  parameter int BUSY_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(BUSY_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
  parameter int IDX_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_q,
  input  logic [IDX_W-1:0] b_idx,
  output logic [DW-1:0]    b_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  // port A: read-first read/write, port B: read only
  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_idx] <= a_wdata;
    end
    a_q <= mem[a_idx];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_idx];
  end
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             consume,
  input  logic             byte_is_cmd,
  input  logic [DW-1:0]    byte_val,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_idx,
  output logic             rd_pend,
  output sq_state_t        state
);
  logic [IDX_W-1:0] idx_q;

  assign rf_we  = consume && !byte_is_cmd && (state == SQ_WR_VAL);
  assign rf_idx = (state == SQ_WR_VAL) ? idx_q : byte_val[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      idx_q   <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= 1'b0;
      if (consume) begin
        if (byte_is_cmd) begin
          if (byte_val == CMD_RD) begin
            state <= SQ_RD_IDX;
          end else if (byte_val == CMD_WR) begin
            state <= SQ_WR_IDX;
          end else begin
            state <= SQ_IDLE;
          end
        end else begin
          case (state)
            SQ_RD_IDX: begin
              rd_pend <= 1'b1;
              state   <= SQ_IDLE;
            end
            SQ_WR_IDX: begin
              idx_q <= byte_val[IDX_W-1:0];
              state <= SQ_WR_VAL;
            end
            SQ_WR_VAL: state <= SQ_IDLE;
            default:   state <= SQ_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int IDX_W    = 4,
  parameter int BUSY_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [IDX_W-1:0]  eng_idx,
  output logic [DW-1:0]     eng_rdata,
  output logic [DW-1:0]     intr_ctrl
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CSR  = ADDR_W'(OFS_CSR);
  localparam logic [ADDR_W-1:0] A_INTC = ADDR_W'(OFS_INTC);

  logic             sel_data, sel_csr, sel_intc;
  logic             accept, ibf, consume;
  logic             hold_cmd;
  logic [DW-1:0]    hold_byte;
  logic             cmd_flag, obf;
  logic [DW-1:0]    outbuf, intc_q, stat_byte;
  logic             rd_pend, rf_we;
  logic [IDX_W-1:0] rf_idx;
  logic [DW-1:0]    rf_q;
  sq_state_t        seq_state;

  assign sel_data = (host_addr == A_DATA);
  assign sel_csr  = (host_addr == A_CSR);
  assign sel_intc = (host_addr == A_INTC);
  assign accept   = host_wr && !ibf && (sel_data || sel_csr);

  mbx_busy #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (ibf),
    .done  (consume)
  );

  mbx_seq #(.IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .consume     (consume),
    .byte_is_cmd (hold_cmd),
    .byte_val    (hold_byte),
    .rf_we       (rf_we),
    .rf_idx      (rf_idx),
    .rd_pend     (rd_pend),
    .state       (seq_state)
  );

  mbx_regfile #(.IDX_W(IDX_W), .DW(DW)) u_rf (
    .clk     (clk),
    .a_we    (rf_we),
    .a_idx   (rf_idx),
    .a_wdata (hold_byte),
    .a_q     (rf_q),
    .b_idx   (eng_idx),
    .b_q     (eng_rdata)
  );

  // captured host byte and command flag
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_byte <= '0;
      hold_cmd  <= 1'b0;
      cmd_flag  <= 1'b0;
    end else if (accept) begin
      hold_byte <= host_wdata;
      hold_cmd  <= sel_csr;
      cmd_flag  <= sel_csr;
    end
  end

  // output buffer: a new result wins over the clearing read
  always_ff @(posedge clk) begin
    if (rst) begin
      outbuf <= '0;
      obf    <= 1'b0;
    end else if (rd_pend) begin
      outbuf <= rf_q;
      obf    <= 1'b1;
    end else if (host_rd && sel_data) begin
      obf    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intc_q <= '0;
    end else if (host_wr && sel_intc) begin
      intc_q <= host_wdata;
    end
  end
  assign intr_ctrl = intc_q;

  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_OBF] = obf;
    stat_byte[ST_IBF] = ibf;
    stat_byte[ST_CMD] = cmd_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (sel_data) begin
        host_rdata <= outbuf;
      end else if (sel_csr) begin
        host_rdata <= stat_byte;
      end else if (sel_intc) begin
        host_rdata <= intc_q;
      end else begin
        host_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/mbx_port_chk.sv
module mbx_port_chk #(
  parameter int ADDR_W   = 4,
  parameter int BUSY_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_rdata,
  input logic              ibf,
  input logic              obf,
  input logic              cmd_flag,
  input logic              consume,
  input logic              hold_cmd,
  input logic              rd_pend,
  input logic [1:0]        seq_state
);
  localparam int RW = $clog2(BUSY_CYC + 2);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CSR  = ADDR_W'(4);

  logic [RW-1:0] ibf_run;

  always_ff @(posedge clk) begin
    if (rst || !ibf) begin
      ibf_run <= '0;
    end else begin
      ibf_run <= ibf_run + RW'(1);
    end
  end

  AST_IBF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ibf |-> (ibf_run < RW'(BUSY_CYC))); // R3

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    (ibf && host_wr && (host_addr == A_DATA || host_addr == A_CSR)) |=> $stable(cmd_flag)); // R4

  AST_LOAD_SETS_OBF: assert property (@(posedge clk) disable iff (rst)
    rd_pend |=> obf); // R6

  AST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_DATA && !rd_pend) |=> !obf); // R8

  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_CSR) |=> ((host_rdata & 8'hF4) == 8'h00)); // R2

  AST_STRAY_DATA: assert property (@(posedge clk) disable iff (rst)
    (consume && !hold_cmd && seq_state == 2'd0) |=> (seq_state == 2'd0 && !rd_pend)); // R10
endmodule

bind mbx_port mbx_port_chk #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .ibf        (ibf),
  .obf        (obf),
  .cmd_flag   (cmd_flag),
  .consume    (consume),
  .hold_cmd   (hold_cmd),
  .rd_pend    (rd_pend),
  .seq_state  (seq_state)
);

// File: tb/mbx_port_test.sv
module mbx_port_test;
  localparam int ADDR_W   = 4;
  localparam int IDX_W    = 4;
  localparam int BUSY_CYC = 3;

  // op codes of the vector table
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WOBF = 2'd2, OP_WIBF = 2'd3;
  localparam int NV = 37;
  // {op, addr, data, expected, requirement number}
  localparam logic [25:0] VEC [NV] = '{
    {OP_WR,   4'h4, 8'h81, 8'h00, 4'd7},  // R7 write reg5 = A5
    {OP_WR,   4'h0, 8'h05, 8'h00, 4'd7},
    {OP_WR,   4'h0, 8'hA5, 8'h00, 4'd7},
    {OP_WR,   4'h4, 8'h81, 8'h00, 4'd7},  // write reg9 = 3C
    {OP_WR,   4'h0, 8'h09, 8'h00, 4'd7},
    {OP_WR,   4'h0, 8'h3C, 8'h00, 4'd7},
    {OP_WR,   4'h4, 8'h80, 8'h00, 4'd6},  // R6 read reg5
    {OP_WIBF, 4'h0, 8'h00, 8'h00, 4'd3},
    {OP_RD,   4'h4, 8'h00, 8'h08, 4'd5},  // R5 command flag only
    {OP_WR,   4'h0, 8'h05, 8'h00, 4'd6},
    {OP_WOBF, 4'h0, 8'h00, 8'h00, 4'd6},
    {OP_RD,   4'h4, 8'h00, 8'h01, 4'd2},  // R2 status layout
    {OP_RD,   4'h0, 8'h00, 8'hA5, 4'd6},
    {OP_RD,   4'h4, 8'h00, 8'h00, 4'd8},  // R8 read cleared OBF
    {OP_WR,   4'h4, 8'h80, 8'h00, 4'd6},  // index high bits ignored
    {OP_WR,   4'h0, 8'h19, 8'h00, 4'd6},
    {OP_WOBF, 4'h0, 8'h00, 8'h00, 4'd6},
    {OP_RD,   4'h0, 8'h00, 8'h3C, 4'd6},
    {OP_WR,   4'h4, 8'h81, 8'h00, 4'd9},  // R9 abort by new command
    {OP_WR,   4'h0, 8'h05, 8'h00, 4'd9},
    {OP_WR,   4'h4, 8'h80, 8'h00, 4'd9},
    {OP_WR,   4'h0, 8'h09, 8'h00, 4'd9},
    {OP_WOBF, 4'h0, 8'h00, 8'h00, 4'd9},
    {OP_RD,   4'h0, 8'h00, 8'h3C, 4'd9},
    {OP_WR,   4'h4, 8'h81, 8'h00, 4'd9},  // unknown command goes idle
    {OP_WR,   4'h0, 8'h05, 8'h00, 4'd9},
    {OP_WR,   4'h4, 8'h22, 8'h00, 4'd9},
    {OP_WR,   4'h0, 8'h77, 8'h00, 4'd10}, // R10 stray byte
    {OP_WIBF, 4'h0, 8'h00, 8'h00, 4'd10},
    {OP_RD,   4'h4, 8'h00, 8'h00, 4'd10},
    {OP_WR,   4'h4, 8'h80, 8'h00, 4'd9},  // reg5 untouched
    {OP_WR,   4'h0, 8'h05, 8'h00, 4'd9},
    {OP_WOBF, 4'h0, 8'h00, 8'h00, 4'd9},
    {OP_RD,   4'h0, 8'h00, 8'hA5, 4'd9},
    {OP_WR,   4'h8, 8'h5A, 8'h00, 4'd12}, // R12 interrupt control
    {OP_RD,   4'h8, 8'h00, 8'h5A, 4'd12},
    {OP_RD,   4'hC, 8'h00, 8'h00, 4'd2}   // unmapped
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic [IDX_W-1:0]  eng_idx = '0;
  logic [7:0]        eng_rdata;
  logic [7:0]        intr_ctrl;

  int errors = 0;
  int total  = 0;

  always #5 clk = ~clk;

  mbx_port #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUSY_CYC(BUSY_CYC)) uut (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_idx    (eng_idx),
    .eng_rdata  (eng_rdata),
    .intr_ctrl  (intr_ctrl)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    host_rd   = 1'b1;
    @(negedge clk);
    host_rd   = 1'b0;
    d         = host_rdata;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    host_addr  = a;
    host_wdata = d;
    host_wr    = 1'b1;
    @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic wait_flag(input int bitpos, input logic want, input string req);
    logic [7:0] s;
    bit ok = 1'b0;
    for (int n = 0; n < 50 && !ok; n++) begin
      host_read(4'h4, s);
      if (s[bitpos] == want) ok = 1'b1;
    end
    if (!ok) begin
      total++;
      errors++;
      $display("FAIL %s: status bit %0d stuck, got %02h expected bit %0b", req, bitpos, s, want);
    end
  endtask

  task automatic put(input logic [3:0] a, input logic [7:0] d);
    wait_flag(1, 1'b0, "R4");
    host_write(a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    total++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", host_rdata, 8'h00);
    check("R1", intr_ctrl, 8'h00);
    host_read(4'h4, r); check("R1", r, 8'h00);
    host_read(4'h0, r); check("R1", r, 8'h00);

    // R10 stray data byte straight after reset
    host_write(4'h0, 8'h07);
    repeat (BUSY_CYC + 3) @(negedge clk);
    host_read(4'h4, r); check("R10", r, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] a;
      logic [7:0] d, e;
      string tag;
      op = VEC[i][25:24];
      a  = VEC[i][23:20];
      d  = VEC[i][19:12];
      e  = VEC[i][11:4];
      tag = $sformatf("R%0d (vector %0d)", VEC[i][3:0], i);
      case (op)
        OP_WR:   put(a, d);
        OP_RD:   begin host_read(a, r); check(tag, r, e); end
        OP_WOBF: wait_flag(0, 1'b1, tag);
        default: wait_flag(1, 1'b0, tag);
      endcase
    end
    check("R12", intr_ctrl, 8'h5A);

    // R3 input-busy lasts exactly BUSY_CYC cycles
    wait_flag(1, 1'b0, "R3");
    host_write(4'h4, 8'h80);
    for (int k = 0; k < BUSY_CYC; k++) begin
      host_read(4'h4, r); check("R3", r & 8'h02, 8'h02);
    end
    host_read(4'h4, r); check("R3", r & 8'h02, 8'h00);

    // R4 write while busy is dropped: index 5 lost, index 9 used
    host_write(4'h0, 8'h09);
    wait_flag(0, 1'b1, "R4");
    host_read(4'h0, r); check("R6", r, 8'h3C);
    wait_flag(1, 1'b0, "R4");
    host_write(4'h4, 8'h80);
    host_write(4'h0, 8'h05);
    put(4'h0, 8'h09);
    wait_flag(0, 1'b1, "R4");
    host_read(4'h0, r); check("R4", r, 8'h3C);

    // R8 result load and clearing read in the same cycle
    put(4'h4, 8'h80);
    put(4'h0, 8'h05);
    wait_flag(0, 1'b1, "R8");
    put(4'h4, 8'h80);
    put(4'h0, 8'h09);
    repeat (BUSY_CYC) @(negedge clk);
    host_read(4'h0, r); check("R8", r, 8'hA5);
    host_read(4'h4, r); check("R8", r, 8'h01);
    host_read(4'h0, r); check("R8", r, 8'h3C);
    host_read(4'h4, r); check("R8", r, 8'h00);

    // R11 engine-side read port
    eng_idx = 4'd5;
    @(negedge clk);
    check("R11", eng_rdata, 8'hA5);
    eng_idx = 4'd9;
    @(negedge clk);
    check("R11", eng_rdata, 8'h3C);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule